// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, once per incoming frame, whether the receive path keeps the frame or drops it. The frame parser presents the 48-bit destination address and the 16-bit length/type field together with a one-cycle strobe. One clock later the filter returns a registered verdict: an accept flag, a code naming the rule that won, and the index of the exact-match slot when that rule was an exact-match hit.

The rules come from static configuration inputs:
- four 48-bit exact-match slots,
- a 64-bin hash table with separate enables for group and individual destinations,
- a type value compared against the length/type field,
- a promiscuous (copy-all) switch,
- a broadcast-suppression switch.

The destination is carried with bit 0 as the least significant bit of the first octet on the wire, so that bit marks a group (multicast) address. When several rules hit, a fixed priority picks the reported rule. Broadcast suppression acts as a veto over every other rule.

Top module: `rxaf_filter`

## Requirements
- R1: During and right after synchronous reset, res_valid, res_accept, res_rule and res_slot are all 0.
- R2: A decision appears on res_valid, res_accept, res_rule and res_slot in the clock cycle after the one where dst_valid is sampled high. res_valid is high for exactly that one cycle. The other outputs hold their value until the next decision.
- R3: A slot is built as {cfg_sa_hi[16k+:16], cfg_sa_lo[32k+:32]} for slot k. A slot equal to dst_addr accepts the frame with rule code 1. res_slot gives the lowest-numbered matching slot, and is 0 for every other rule code.
- R4: A slot whose 48-bit value is zero is disabled and never matches, not even a zero destination.
- R5: A non-zero cfg_type_id equal to len_type accepts the frame with rule code 2. A cfg_type_id of zero never matches.
- R6: A destination of all ones is accepted with rule code 3 while cfg_no_bcast is 0.
- R7: When cfg_no_bcast is 1, an all-ones destination is rejected with rule code 0, whatever the slots, type value, hash and copy-all settings are.
- R8: Hash lookup uses a 6-bit bin. Bin bit i is the XOR of dst_addr bits i, i+6, i+12 and so on up to bit 47. Bins 0..31 are read from cfg_hash_lo[bin] and bins 32..63 from cfg_hash_hi[bin-32]. A group destination (dst_addr[0]=1) that is not broadcast is accepted with rule code 4 when cfg_mc_hash_en is 1 and its bin bit is set.
- R9: An individual destination (dst_addr[0]=0) is accepted through the same hash lookup only when cfg_uc_hash_en is 1. cfg_mc_hash_en has no effect on individual destinations, and cfg_uc_hash_en has no effect on group destinations.
- R10: With cfg_copy_all at 1, every frame is accepted except a broadcast vetoed under R7. The rule code is 5 when no other rule hits.
- R11: When several rules hit, the reported code follows the priority exact-match (1) > type (2) > broadcast (3) > hash (4) > copy-all (5).
- R12: When no rule hits, res_accept is 0 and res_rule is 0. Whenever res_valid is 1, res_accept is 1 exactly when res_rule is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dst_valid | input | 1 | One-cycle strobe: dst_addr and len_type are complete |
| dst_addr | input | 48 | Destination address; bit 0 is the LSB of the first octet |
| len_type | input | 16 | Received length/type field |
| cfg_copy_all | input | 1 | Accept all frames |
| cfg_no_bcast | input | 1 | Reject all-ones destinations |
| cfg_mc_hash_en | input | 1 | Hash acceptance for group destinations |
| cfg_uc_hash_en | input | 1 | Hash acceptance for individual destinations |
| cfg_hash_lo | input | 32 | Hash bins 0..31 |
| cfg_hash_hi | input | 32 | Hash bins 32..63 |
| cfg_sa_lo | input | 128 | Low 32 bits of each exact-match slot, slot k at [32k+:32] |
| cfg_sa_hi | input | 64 | High 16 bits of each exact-match slot, slot k at [16k+:16] |
| cfg_type_id | input | 16 | Type value to compare; 0 disables the comparison |
| res_valid | output | 1 | Decision strobe |
| res_accept | output | 1 | Frame accepted |
| res_rule | output | 3 | Winning rule code (0 none, 1 slot, 2 type, 3 broadcast, 4 hash, 5 copy-all) |
| res_slot | output | 2 | Matching slot index for rule code 1, else 0 |

## Verification
The bench builds the filter with its default parameters: four exact-match slots and a 6-bit hash bin. With four slots it can set two slots to the same address and check the lowest-index choice, and also leave a slot at zero to check that it stays disabled. The 64-bin table spans both configuration words, so destinations are chosen whose bins fall at 1, 2 and 33. Those bins exercise the low word, the high word and the split between group and individual destinations.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int ADDR_W = 48;
    localparam int HASH_W = 6;
    localparam int TYPE_W = 16;

    typedef enum logic [2:0] {
        RULE_NONE  = 3'd0,
        RULE_SPEC  = 3'd1,
        RULE_TYPE  = 3'd2,
        RULE_BCAST = 3'd3,
        RULE_HASH  = 3'd4,
        RULE_ALL   = 3'd5
    } rule_e;

    // Raw rule hits before the broadcast veto and priority selection
    typedef struct packed {
        logic spec;
        logic tid;
        logic bcast;
        logic hash;
        logic all;
    } hits_t;

    // Fold the address into a bin: bit i collects every HASH_W-th bit from i
    function automatic logic [HASH_W-1:0] hash_fold(input logic [ADDR_W-1:0] a);
        logic [HASH_W-1:0] r;
        r = '0;
        for (int i = 0; i < HASH_W; i++) begin
            for (int j = i; j < ADDR_W; j += HASH_W) begin
                r[i] = r[i] ^ a[j];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rxaf_sa_bank.sv
module rxaf_sa_bank
    import rxaf_pkg::*;
#(
    parameter int NUM_SA = 4,
    parameter int LO_W   = 32,
    parameter int SLOT_W = 2
) (
    input  logic [ADDR_W-1:0]              dst,
    input  logic [NUM_SA*LO_W-1:0]         sa_lo,
    input  logic [NUM_SA*(ADDR_W-LO_W)-1:0] sa_hi,
    output logic [NUM_SA-1:0]              hit_vec,
    output logic                           any_hit,
    output logic [SLOT_W-1:0]              first_slot
);
    localparam int HI_W = ADDR_W - LO_W;

    for (genvar k = 0; k < NUM_SA; k++) begin : g_slot
        logic [ADDR_W-1:0] slot_val;
        assign slot_val   = {sa_hi[k*HI_W +: HI_W], sa_lo[k*LO_W +: LO_W]};
        // An all-zero slot is treated as unused
        assign hit_vec[k] = (|slot_val) && (slot_val == dst);
    end

    assign any_hit = |hit_vec;

    // Scan from the top down so the lowest matching index is left in first_slot
    always_comb begin
        first_slot = '0;
        for (int k = NUM_SA - 1; k >= 0; k--) begin
            if (hit_vec[k]) first_slot = SLOT_W'(k);
        end
    end

endmodule

// File: rtl/rxaf_hash_lookup.sv
module rxaf_hash_lookup
    import rxaf_pkg::*;
#(
    parameter int BINS = 64
) (
    input  logic [ADDR_W-1:0]   dst,
    input  logic [BINS/2-1:0]   tbl_lo,
    input  logic [BINS/2-1:0]   tbl_hi,
    input  logic                mc_en,
    input  logic                uc_en,
    input  logic                is_bcast,
    output logic                hit
);
    logic [BINS-1:0]   tbl;
    logic [HASH_W-1:0] bin;
    logic              class_en;

    assign tbl      = {tbl_hi, tbl_lo};
    assign bin      = hash_fold(dst);
    // Group destinations use the multicast enable, individual ones the unicast enable
    assign class_en = dst[0] ? mc_en : uc_en;
    assign hit      = class_en && !is_bcast && tbl[bin];

endmodule

// File: rtl/rxaf_arbiter.sv
module rxaf_arbiter
    import rxaf_pkg::*;
(
    input  hits_t  hits,
    input  logic   veto,
    output logic   accept,
    output rule_e  rule
);
    always_comb begin
        rule = RULE_NONE;
        if (!veto) begin
            if      (hits.spec)  rule = RULE_SPEC;
            else if (hits.tid)   rule = RULE_TYPE;
            else if (hits.bcast) rule = RULE_BCAST;
            else if (hits.hash)  rule = RULE_HASH;
            else if (hits.all)   rule = RULE_ALL;
        end
    end

    assign accept = !veto && (hits.spec || hits.tid || hits.bcast || hits.hash || hits.all);

endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter
    import rxaf_pkg::*;
#(
    parameter int NUM_SA    = 4,
    parameter int HASH_BINS = 64,
    parameter int SA_LO_W   = 32,
    localparam int SA_HI_W  = ADDR_W - SA_LO_W,
    localparam int SLOT_W   = (NUM_SA > 1) ? $clog2(NUM_SA) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        dst_valid,
    input  logic [ADDR_W-1:0]           dst_addr,
    input  logic [TYPE_W-1:0]           len_type,
    input  logic                        cfg_copy_all,
    input  logic                        cfg_no_bcast,
    input  logic                        cfg_mc_hash_en,
    input  logic                        cfg_uc_hash_en,
    input  logic [HASH_BINS/2-1:0]      cfg_hash_lo,
    input  logic [HASH_BINS/2-1:0]      cfg_hash_hi,
    input  logic [NUM_SA*SA_LO_W-1:0]   cfg_sa_lo,
    input  logic [NUM_SA*SA_HI_W-1:0]   cfg_sa_hi,
    input  logic [TYPE_W-1:0]           cfg_type_id,
    output logic                        res_valid,
    output logic                        res_accept,
    output logic [2:0]                  res_rule,
    output logic [SLOT_W-1:0]           res_slot
);
    logic [NUM_SA-1:0] sa_hit;
    logic              sa_any;
    logic [SLOT_W-1:0] sa_first;
    logic              is_bcast;
    logic              hash_hit;
    hits_t             hits;
    logic              acc_d;
    rule_e             rule_d;

    assign is_bcast = &dst_addr;

    rxaf_sa_bank #(.NUM_SA(NUM_SA), .LO_W(SA_LO_W), .SLOT_W(SLOT_W)) u_sa (
        .dst        (dst_addr),
        .sa_lo      (cfg_sa_lo),
        .sa_hi      (cfg_sa_hi),
        .hit_vec    (sa_hit),
        .any_hit    (sa_any),
        .first_slot (sa_first)
    );

    rxaf_hash_lookup #(.BINS(HASH_BINS)) u_hash (
        .dst      (dst_addr),
        .tbl_lo   (cfg_hash_lo),
        .tbl_hi   (cfg_hash_hi),
        .mc_en    (cfg_mc_hash_en),
        .uc_en    (cfg_uc_hash_en),
        .is_bcast (is_bcast),
        .hit      (hash_hit)
    );

    assign hits.spec  = sa_any;
    assign hits.tid   = (|cfg_type_id) && (cfg_type_id == len_type);
    assign hits.bcast = is_bcast;
    assign hits.hash  = hash_hit;
    assign hits.all   = cfg_copy_all;

    rxaf_arbiter u_arb (
        .hits   (hits),
        .veto   (cfg_no_bcast && is_bcast),
        .accept (acc_d),
        .rule   (rule_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_rule   <= RULE_NONE;
            res_slot   <= '0;
        end else begin
            res_valid <= dst_valid;
            if (dst_valid) begin
                res_accept <= acc_d;
                res_rule   <= rule_d;
                res_slot   <= (rule_d == RULE_SPEC) ? sa_first : '0;
            end
        end
    end

    // R2: a decision follows every strobe by one cycle, and only then
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        dst_valid |=> res_valid);
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        !dst_valid |=> !res_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !dst_valid |=> ($stable(res_rule) && $stable(res_accept) && $stable(res_slot)));
    // R3: the reported slot is one that actually matched
    p_first_slot_r3: assert property (@(posedge clk) disable iff (rst)
        sa_any |-> sa_hit[sa_first]);
    // R4: a zero destination can never hit a slot
    p_zero_slot_r4: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && dst_addr == '0) |=> (res_rule != RULE_SPEC));
    // R7: suppressed broadcast is always rejected
    p_bcast_block_r7: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && cfg_no_bcast && is_bcast) |=> (!res_accept && res_rule == RULE_NONE));
    // R10: copy-all accepts everything that is not vetoed
    p_copy_all_r10: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && cfg_copy_all && !(cfg_no_bcast && is_bcast)) |=> res_accept);
    // R12: accept flag agrees with the rule code
    p_accept_rule_r12: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_accept == (res_rule != 3'd0)));

endmodule

// File: tb/tb_rxaf_filter.sv
module tb_rxaf_filter;

    logic         clk = 1'b0;
    logic         rst;
    logic         dst_valid;
    logic [47:0]  dst_addr;
    logic [15:0]  len_type;
    logic         cfg_copy_all, cfg_no_bcast, cfg_mc_hash_en, cfg_uc_hash_en;
    logic [31:0]  cfg_hash_lo, cfg_hash_hi;
    logic [127:0] cfg_sa_lo;
    logic [63:0]  cfg_sa_hi;
    logic [15:0]  cfg_type_id;
    logic         res_valid, res_accept;
    logic [2:0]   res_rule;
    logic [1:0]   res_slot;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rxaf_filter dut (
        .clk(clk), .rst(rst), .dst_valid(dst_valid), .dst_addr(dst_addr),
        .len_type(len_type), .cfg_copy_all(cfg_copy_all), .cfg_no_bcast(cfg_no_bcast),
        .cfg_mc_hash_en(cfg_mc_hash_en), .cfg_uc_hash_en(cfg_uc_hash_en),
        .cfg_hash_lo(cfg_hash_lo), .cfg_hash_hi(cfg_hash_hi),
        .cfg_sa_lo(cfg_sa_lo), .cfg_sa_hi(cfg_sa_hi), .cfg_type_id(cfg_type_id),
        .res_valid(res_valid), .res_accept(res_accept), .res_rule(res_rule),
        .res_slot(res_slot)
    );

    // Bin per the requirement: bit i is the XOR of address bits i, i+6, ...
    function automatic int bin_of(input logic [47:0] a);
        int b = 0;
        for (int i = 0; i < 6; i++) begin
            logic x = 1'b0;
            for (int j = i; j < 48; j += 6) x ^= a[j];
            if (x) b += (1 << i);
        end
        return b;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_cfg();
        cfg_copy_all = 0; cfg_no_bcast = 0; cfg_mc_hash_en = 0; cfg_uc_hash_en = 0;
        cfg_hash_lo = '0; cfg_hash_hi = '0; cfg_sa_lo = '0; cfg_sa_hi = '0;
        cfg_type_id = '0;
    endtask

    task automatic set_slot(input int k, input logic [47:0] v);
        cfg_sa_lo[k*32 +: 32] = v[31:0];
        cfg_sa_hi[k*16 +: 16] = v[47:32];
    endtask

    task automatic set_bin(input int b);
        if (b < 32) cfg_hash_lo[b] = 1'b1;
        else        cfg_hash_hi[b-32] = 1'b1;
    endtask

    // Present one frame, then sample the registered decision at the next falling edge
    task automatic decide(input string tag, input logic [47:0] a, input logic [15:0] lt,
                          input logic acc, input logic [2:0] rule, input logic [1:0] slot);
        @(negedge clk);
        dst_addr = a; len_type = lt; dst_valid = 1'b1;
        @(negedge clk);
        dst_valid = 1'b0;
        chk({tag, " valid"}, 32'(res_valid), 32'd1);
        chk({tag, " accept"}, 32'(res_accept), 32'(acc));
        chk({tag, " rule"}, 32'(res_rule), 32'(rule));
        chk({tag, " slot"}, 32'(res_slot), 32'(slot));
    endtask

    task automatic t_reset();
        rst = 1; dst_valid = 0; dst_addr = '0; len_type = '0; clear_cfg();
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(res_valid), 0);
        chk("R1 accept in reset", 32'(res_accept), 0);
        chk("R1 rule in reset", 32'(res_rule), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 valid after reset", 32'(res_valid), 0);
        chk("R1 slot after reset", 32'(res_slot), 0);
    endtask

    task automatic t_none();
        clear_cfg();
        decide("R12 no rule", 48'h1234_5678_9AB0, 16'h0800, 0, 3'd0, 2'd0);
    endtask

    task automatic t_spec();
        clear_cfg();
        set_slot(2, 48'hA1B2_C3D4_E5F6);
        decide("R3 slot2", 48'hA1B2_C3D4_E5F6, 16'h0800, 1, 3'd1, 2'd2);
        set_slot(1, 48'h0050_C2AA_BB00);
        set_slot(3, 48'h0050_C2AA_BB00);
        decide("R3 lowest slot", 48'h0050_C2AA_BB00, 16'h0800, 1, 3'd1, 2'd1);
        decide("R3 near miss", 48'h0050_C2AA_BB02, 16'h0800, 0, 3'd0, 2'd0);
        // slot 0 stays zero: a zero destination must not match it
        decide("R4 zero slot", 48'h0, 16'h0800, 0, 3'd0, 2'd0);
    endtask

    task automatic t_type();
        clear_cfg();
        cfg_type_id = 16'h88F7;
        decide("R5 type hit", 48'h0000_1111_2220, 16'h88F7, 1, 3'd2, 2'd0);
        decide("R5 type miss", 48'h0000_1111_2220, 16'h88F8, 0, 3'd0, 2'd0);
        cfg_type_id = 16'h0;
        decide("R5 zero type", 48'h0000_1111_2220, 16'h0000, 0, 3'd0, 2'd0);
    endtask

    task automatic t_bcast();
        clear_cfg();
        decide("R6 bcast", 48'hFFFF_FFFF_FFFF, 16'h0806, 1, 3'd3, 2'd0);
        cfg_no_bcast = 1; cfg_copy_all = 1; cfg_mc_hash_en = 1;
        cfg_hash_lo = '1; cfg_hash_hi = '1; cfg_type_id = 16'h0806;
        set_slot(0, 48'hFFFF_FFFF_FFFF);
        decide("R7 veto", 48'hFFFF_FFFF_FFFF, 16'h0806, 0, 3'd0, 2'd0);
    endtask

    task automatic t_mc_hash();
        clear_cfg();
        cfg_mc_hash_en = 1;
        set_bin(bin_of(48'h0000_0000_0021));
        decide("R8 mc high word", 48'h0000_0000_0021, 16'h0800, 1, 3'd4, 2'd0);
        set_bin(bin_of(48'h0000_0000_0001));
        decide("R8 mc low word", 48'h0000_0000_0001, 16'h0800, 1, 3'd4, 2'd0);
        decide("R8 bin clear", 48'h0000_0000_0003, 16'h0800, 0, 3'd0, 2'd0);
        cfg_mc_hash_en = 0; cfg_uc_hash_en = 1;
        decide("R9 uc en ignored for mc", 48'h0000_0000_0001, 16'h0800, 0, 3'd0, 2'd0);
    endtask

    task automatic t_uc_hash();
        clear_cfg();
        set_bin(bin_of(48'h0000_0000_0002));
        cfg_uc_hash_en = 1;
        decide("R9 uc hit", 48'h0000_0000_0002, 16'h0800, 1, 3'd4, 2'd0);
        cfg_uc_hash_en = 0; cfg_mc_hash_en = 1;
        decide("R9 mc en ignored for uc", 48'h0000_0000_0002, 16'h0800, 0, 3'd0, 2'd0);
    endtask

    task automatic t_copy_all();
        clear_cfg();
        cfg_copy_all = 1;
        decide("R10 copy all uc", 48'h3C4D_5E6F_7080, 16'h0800, 1, 3'd5, 2'd0);
        decide("R10 copy all mc", 48'h3C4D_5E6F_7081, 16'h0042, 1, 3'd5, 2'd0);
    endtask

    task automatic t_priority();
        logic [47:0] a = 48'h0000_0000_0001;
        clear_cfg();
        cfg_copy_all = 1; cfg_mc_hash_en = 1; set_bin(bin_of(a));
        cfg_type_id = 16'h9000; set_slot(3, a);
        decide("R11 slot wins", a, 16'h9000, 1, 3'd1, 2'd3);
        set_slot(3, 48'h0);
        decide("R11 type over hash", a, 16'h9000, 1, 3'd2, 2'd0);
        decide("R11 hash over all", a, 16'h0800, 1, 3'd4, 2'd0);
        decide("R11 type over bcast", 48'hFFFF_FFFF_FFFF, 16'h9000, 1, 3'd2, 2'd0);
        decide("R11 bcast over all", 48'hFFFF_FFFF_FFFF, 16'h0800, 1, 3'd3, 2'd0);
    endtask

    task automatic t_timing();
        clear_cfg();
        cfg_type_id = 16'h1234;
        decide("R2 first", 48'h0000_0000_0010, 16'h1234, 1, 3'd2, 2'd0);
        // input changes without a strobe must not disturb the held result
        dst_addr = 48'hFFFF_FFFF_FFFF; len_type = 16'h0;
        repeat (3) begin
            @(negedge clk);
            chk("R2 valid pulse", 32'(res_valid), 0);
            chk("R2 hold rule", 32'(res_rule), 2);
            chk("R2 hold accept", 32'(res_accept), 1);
        end
    endtask

    initial begin
        t_reset();
        t_none();
        t_spec();
        t_type();
        t_bcast();
        t_mc_hash();
        t_uc_hash();
        t_copy_all();
        t_priority();
        t_timing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule